// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps a free-running time of day as a 48-bit seconds count and a 30-bit nanoseconds count. On every clock the nanoseconds advance by a programmable increment. The increment has a whole-nanosecond part and a binary fraction of a nanosecond. The fraction builds up in an accumulator, and each carry out of that accumulator adds one extra nanosecond on the clock where it happens. When the nanoseconds reach one billion, they wrap and the seconds count steps up by one.

Software controls the counter through a single-word write port and a combinational read port. Through these it can load the time, change the increment, and apply a one-shot signed nanosecond correction. The seconds high word and the fractional increment are both staged: each takes effect only when its partner register is written. This lets the recommended set-time sequence load the time exactly, and it lets an increment change land on one clock. Reading the low seconds word freezes a copy of the seconds high word and the nanoseconds, so a multi-word read stays coherent.

The block gives two interrupt pulses, and each one can be masked on its own. The first marks every seconds carry. The second fires when the time first reaches or passes a programmed compare point.

Top module: `ptp_tod_counter`

## Requirements
- R1: Synchronous active-low reset clears the seconds, nanoseconds, fraction accumulator, compare registers and interrupt enables. It loads the increment with the parameter defaults (8 whole, fraction 0). Both interrupt outputs are low.
- R2: On each clock without a register write that changes the time, nanoseconds advance by whole + c. Here c is the carry out of the 16-bit sum of the accumulator and the fraction. The accumulator keeps the low 16 bits of that sum.
- R3: A write to address 3 (fraction, bits 15:0) only stages the value. Both address 3 and address 4 read back the active increment. A write to address 4 (whole, bits 7:0) commits the whole value and the staged fraction together. The new increment is used from the following clock on.
- R4: A write to address 0 (bits 15:0) stages the seconds high word and leaves the running seconds unchanged. A write to address 1 loads the seconds as {staged high, data}. On that clock the nanoseconds and the accumulator hold.
- R5: A write to address 2 with bits 29:0 below 1,000,000,000 sets the nanoseconds to exactly that value and clears the accumulator. A larger value is ignored, and the counter advances normally.
- R6: When the nanoseconds would reach or exceed 1,000,000,000, one billion is subtracted and the seconds count increments. The 48-bit seconds wrap to zero.
- R7: A write to address 5 applies bit 31 as sign (1 = subtract) and bits 29:0 as magnitude to the nanoseconds, in place of that clock's increment, with the accumulator held. A result of one billion or more carries a second. A negative result borrows a second. A magnitude of one billion or more is ignored.
- R8: With both increment parts zero and no write, the time stays constant.
- R9: The seconds interrupt is high for one clock with the new seconds value after each rollover carry (R6, R7). It is gated by enable bit 0 at address 8. Loads of the seconds never raise it.
- R10: The compare interrupt pulses for one clock when {seconds[31:0], nanoseconds} is not below {address 6, address 7} after having been below it on the previous clock. A compare write on that previous clock suppresses the pulse. It is gated by enable bit 1 at address 8.
- R11: A read of address 1 (with the read strobe) returns the live low seconds word. The same read snapshots the seconds high word and the nanoseconds, which addresses 0 and 2 then return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Read strobe; takes the snapshot when addressing the low seconds |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Combinational read data |
| tod_sec_o | output | 48 | Running seconds |
| tod_ns_o | output | 30 | Running nanoseconds |
| pps_irq_o | output | 1 | Seconds-carry interrupt pulse |
| cmp_irq_o | output | 1 | Time-compare interrupt pulse |

## Verification
The counter is driven with integer-only increments, with fractional increments whose carry lands on some clocks and not others, and with a zero increment. This separates a lost or doubled fraction carry from a wrong whole step. The set-time sequence is run near a seconds and a high-word boundary, which shows whether the staged high word and the rollover carry interact correctly. Adjust writes are used as an add that crosses a second, as a subtract that borrows one, and as an out-of-range value, so carry, borrow and rejection are each seen alone. A long random mix of writes and reads is then checked cycle by cycle against a reference model, including compare points set just ahead of and just behind the running time.

// File: rtl/tod_pkg.sv
// Shared constants and types for the time-of-day counter.
// Assumes a 32-bit register data path and a 30-bit nanosecond field.
package tod_pkg;
    localparam int NS_W       = 30;
    localparam int NS_PER_SEC = 1_000_000_000;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 32;

    typedef enum logic [ADDR_W-1:0] {
        REG_SEC_HI    = 4'd0,
        REG_SEC_LO    = 4'd1,
        REG_NSEC      = 4'd2,
        REG_INC_FRAC  = 4'd3,
        REG_INC_WHOLE = 4'd4,
        REG_ADJUST    = 4'd5,
        REG_CMP_SEC   = 4'd6,
        REG_CMP_NS    = 4'd7,
        REG_IRQ_EN    = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic ld_sec;
        logic ld_ns;
        logic adj_en;
        logic adj_sub;
    } tod_load_t;
endpackage

// File: rtl/tod_incr.sv
// Increment generator: holds the active whole/fraction increment, a staged
// fraction, and the fraction accumulator. Produces the nanosecond step for
// the current clock. Assumes one register write per clock.
module tod_incr #(
    parameter int FRAC_W    = 16,
    parameter int WHOLE_W   = 8,
    parameter int RST_WHOLE = 8,
    parameter int RST_FRAC  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_frac,
    input  logic               ld_whole,
    input  logic [FRAC_W-1:0]  frac_in,
    input  logic [WHOLE_W-1:0] whole_in,
    input  logic               clr_acc,
    input  logic               hold,
    output logic [WHOLE_W:0]   step_o,
    output logic [FRAC_W-1:0]  act_frac_o,
    output logic [WHOLE_W-1:0] act_whole_o
);
    logic [FRAC_W-1:0]  stage_frac_q;
    logic [FRAC_W-1:0]  act_frac_q;
    logic [WHOLE_W-1:0] act_whole_q;
    logic [FRAC_W-1:0]  acc_q;
    logic [FRAC_W:0]    acc_sum;

    // Fraction sum and this clock's whole-nanosecond step.
    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, act_frac_q};
        step_o  = {1'b0, act_whole_q} + {{WHOLE_W{1'b0}}, acc_sum[FRAC_W]};
    end

    // Staging and commit of the increment pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_frac_q <= '0;
            act_frac_q   <= FRAC_W'(RST_FRAC);
            act_whole_q  <= WHOLE_W'(RST_WHOLE);
        end else begin
            if (ld_frac)
                stage_frac_q <= frac_in;
            if (ld_whole) begin
                act_whole_q <= whole_in;
                act_frac_q  <= stage_frac_q;
            end
        end
    end

    // Fraction accumulator: cleared on nanosecond load, held on seconds load/adjust.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clr_acc)
            acc_q <= '0;
        else if (!hold)
            acc_q <= acc_sum[FRAC_W-1:0];
    end

    assign act_frac_o  = act_frac_q;
    assign act_whole_o = act_whole_q;

    // R3
    frac_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_whole |=> $stable(act_frac_q));
endmodule

// File: rtl/tod_core.sv
// Seconds/nanoseconds state. Applies the per-clock step, loads, and the
// signed one-shot adjust, normalising the nanoseconds into [0, 1e9).
// Assumes adjust magnitude and loaded nanoseconds are already range-checked.
module tod_core
    import tod_pkg::*;
#(
    parameter int SEC_W  = 48,
    parameter int STEP_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step_i,
    input  tod_load_t         ld_i,
    input  logic [SEC_W-1:0]  sec_val_i,
    input  logic [NS_W-1:0]   ns_val_i,
    output logic [SEC_W-1:0]  sec_o,
    output logic [NS_W-1:0]   ns_o,
    output logic              carry_o
);
    localparam int SW = NS_W + 3;

    logic [SEC_W-1:0] sec_q;
    logic [NS_W-1:0]  ns_q;
    logic             carry_q;
    logic [SW-1:0]    sum;
    logic [SW-1:0]    fixed;
    logic             neg;
    logic             over;

    // Next nanoseconds: step or signed adjust, then one wrap or borrow.
    always_comb begin
        if (ld_i.adj_en)
            sum = ld_i.adj_sub ? SW'(ns_q) - SW'(ns_val_i) : SW'(ns_q) + SW'(ns_val_i);
        else
            sum = SW'(ns_q) + SW'(step_i);
        neg  = sum[SW-1];
        over = !neg && (sum >= SW'(NS_PER_SEC));
        if (neg)
            fixed = sum + SW'(NS_PER_SEC);
        else if (over)
            fixed = sum - SW'(NS_PER_SEC);
        else
            fixed = sum;
    end

    // Time registers and the rollover carry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q   <= '0;
            ns_q    <= '0;
            carry_q <= 1'b0;
        end else if (ld_i.ld_sec) begin
            sec_q   <= sec_val_i;
            carry_q <= 1'b0;
        end else if (ld_i.ld_ns) begin
            ns_q    <= ns_val_i;
            carry_q <= 1'b0;
        end else begin
            ns_q    <= fixed[NS_W-1:0];
            carry_q <= over;
            if (over)
                sec_q <= sec_q + SEC_W'(1);
            else if (neg)
                sec_q <= sec_q - SEC_W'(1);
        end
    end

    assign sec_o   = sec_q;
    assign ns_o    = ns_q;
    assign carry_o = carry_q;

    // R6
    ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ns_q < NS_W'(NS_PER_SEC));
    // R9
    pps_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_q |-> sec_q == $past(sec_q) + SEC_W'(1));
    // R8
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == '0 && !ld_i.ld_sec && !ld_i.ld_ns && !ld_i.adj_en)
        |=> ($stable(ns_q) && $stable(sec_q)));
    // R4
    sec_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i.ld_sec |=> ns_q == $past(ns_q));
endmodule

// File: rtl/tod_cmp.sv
// Time-compare detector: pulses when the time key first stops being below the
// reference key. A reference write clears the history so no stale pulse fires.
module tod_cmp #(
    parameter int KEY_W = 62
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] now_i,
    input  logic [KEY_W-1:0] ref_i,
    input  logic             ref_wr_i,
    output logic             hit_o
);
    logic below;
    logic below_d;

    // Current ordering of time against the reference.
    assign below = now_i < ref_i;

    // History of the ordering, reset by reference writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            below_d <= 1'b0;
        else
            below_d <= ref_wr_i ? 1'b0 : below;
    end

    assign hit_o = below_d && !below;

    // R10
    cmp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);
endmodule

// File: rtl/ptp_tod_counter.sv
// Top of the time-of-day counter: register decode, staged seconds high word,
// compare and interrupt-enable registers, coherent read snapshot, and the
// interrupt gating. Assumes SEC_W is above 32 and one write per clock.
module ptp_tod_counter
    import tod_pkg::*;
#(
    parameter int SEC_W     = 48,
    parameter int FRAC_W    = 16,
    parameter int WHOLE_W   = 8,
    parameter int RST_WHOLE = 8,
    parameter int RST_FRAC  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEC_W-1:0]  tod_sec_o,
    output logic [NS_W-1:0]   tod_ns_o,
    output logic              pps_irq_o,
    output logic              cmp_irq_o
);
    localparam int HI_W   = SEC_W - 32;
    localparam int STEP_W = WHOLE_W + 1;
    localparam int KEY_W  = 32 + NS_W;

    logic               w_hi, w_lo, w_ns, w_frac, w_whole, w_adj, w_csec, w_cns, w_en;
    logic               val_ok;
    tod_load_t          ld;
    logic [STEP_W-1:0]  step;
    logic [FRAC_W-1:0]  act_frac;
    logic [WHOLE_W-1:0] act_whole;
    logic [SEC_W-1:0]   sec;
    logic [NS_W-1:0]    ns;
    logic               carry;
    logic               cmp_hit;
    logic [HI_W-1:0]    stage_hi_q;
    logic [31:0]        cmp_sec_q;
    logic [NS_W-1:0]    cmp_ns_q;
    logic [1:0]         irq_en_q;
    logic [HI_W-1:0]    snap_hi_q;
    logic [NS_W-1:0]    snap_ns_q;

    // Write address decode and range check of nanosecond-sized values.
    always_comb begin
        w_hi    = wr_en && (wr_addr == REG_SEC_HI);
        w_lo    = wr_en && (wr_addr == REG_SEC_LO);
        w_ns    = wr_en && (wr_addr == REG_NSEC);
        w_frac  = wr_en && (wr_addr == REG_INC_FRAC);
        w_whole = wr_en && (wr_addr == REG_INC_WHOLE);
        w_adj   = wr_en && (wr_addr == REG_ADJUST);
        w_csec  = wr_en && (wr_addr == REG_CMP_SEC);
        w_cns   = wr_en && (wr_addr == REG_CMP_NS);
        w_en    = wr_en && (wr_addr == REG_IRQ_EN);
        val_ok  = wr_data[NS_W-1:0] < NS_W'(NS_PER_SEC);
        ld.ld_sec  = w_lo;
        ld.ld_ns   = w_ns && val_ok;
        ld.adj_en  = w_adj && val_ok;
        ld.adj_sub = wr_data[DATA_W-1];
    end

    tod_incr #(
        .FRAC_W    (FRAC_W),
        .WHOLE_W   (WHOLE_W),
        .RST_WHOLE (RST_WHOLE),
        .RST_FRAC  (RST_FRAC)
    ) i_incr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_frac     (w_frac),
        .ld_whole    (w_whole),
        .frac_in     (wr_data[FRAC_W-1:0]),
        .whole_in    (wr_data[WHOLE_W-1:0]),
        .clr_acc     (ld.ld_ns),
        .hold        (ld.ld_sec || ld.adj_en),
        .step_o      (step),
        .act_frac_o  (act_frac),
        .act_whole_o (act_whole)
    );

    tod_core #(
        .SEC_W  (SEC_W),
        .STEP_W (STEP_W)
    ) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .ld_i      (ld),
        .sec_val_i ({stage_hi_q, wr_data}),
        .ns_val_i  (wr_data[NS_W-1:0]),
        .sec_o     (sec),
        .ns_o      (ns),
        .carry_o   (carry)
    );

    tod_cmp #(
        .KEY_W (KEY_W)
    ) i_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .now_i    ({sec[31:0], ns}),
        .ref_i    ({cmp_sec_q, cmp_ns_q}),
        .ref_wr_i (w_csec || w_cns),
        .hit_o    (cmp_hit)
    );

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_hi_q <= '0;
            cmp_sec_q  <= '0;
            cmp_ns_q   <= '0;
            irq_en_q   <= '0;
        end else begin
            if (w_hi)   stage_hi_q <= wr_data[HI_W-1:0];
            if (w_csec) cmp_sec_q  <= wr_data;
            if (w_cns)  cmp_ns_q   <= wr_data[NS_W-1:0];
            if (w_en)   irq_en_q   <= wr_data[1:0];
        end
    end

    // Snapshot of the upper seconds and nanoseconds on a low-seconds read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_hi_q <= '0;
            snap_ns_q <= '0;
        end else if (rd_en && rd_addr == REG_SEC_LO) begin
            snap_hi_q <= sec[SEC_W-1:32];
            snap_ns_q <= ns;
        end
    end

    // Combinational read multiplexer.
    always_comb begin
        case (rd_addr)
            REG_SEC_HI:    rd_data = DATA_W'(snap_hi_q);
            REG_SEC_LO:    rd_data = sec[31:0];
            REG_NSEC:      rd_data = DATA_W'(snap_ns_q);
            REG_INC_FRAC:  rd_data = DATA_W'(act_frac);
            REG_INC_WHOLE: rd_data = DATA_W'(act_whole);
            REG_CMP_SEC:   rd_data = cmp_sec_q;
            REG_CMP_NS:    rd_data = DATA_W'(cmp_ns_q);
            REG_IRQ_EN:    rd_data = DATA_W'(irq_en_q);
            default:       rd_data = '0;
        endcase
    end

    assign tod_sec_o = sec;
    assign tod_ns_o  = ns;
    assign pps_irq_o = carry && irq_en_q[0];
    assign cmp_irq_o = cmp_hit && irq_en_q[1];
endmodule

// File: tb/test_ptp_tod_counter.sv
module test_ptp_tod_counter;
    localparam int CLK_PERIOD = 10;
    localparam longint BIL = 64'd1_000_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [47:0] tod_sec_o;
    logic [29:0] tod_ns_o;
    logic        pps_irq_o;
    logic        cmp_irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int cmp_cnt = 0;
    bit done = 1'b0;

    // reference model state
    logic [47:0] m_sec;
    longint      m_ns;
    logic [15:0] m_frac, m_incf, m_stf, m_hi, m_snap_hi;
    logic [7:0]  m_incn;
    logic [31:0] m_cs;
    logic [29:0] m_cn, m_snap_ns;
    logic [1:0]  m_en;
    bit          e_pps, e_cmp;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_tod_counter i_ptp_tod_counter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tod_sec_o(tod_sec_o),
        .tod_ns_o(tod_ns_o), .pps_irq_o(pps_irq_o), .cmp_irq_o(cmp_irq_o)
    );

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit below(logic [47:0] s, longint n, logic [31:0] cs, logic [29:0] cn);
        logic [61:0] a, b;
        a = {s[31:0], 30'(n)};
        b = {cs, cn};
        return a < b;
    endfunction

    function automatic logic [31:0] exp_read(logic [3:0] ra);
        case (ra)
            4'd0: return 32'(m_snap_hi);
            4'd1: return m_sec[31:0];
            4'd2: return 32'(m_snap_ns);
            4'd3: return 32'(m_incf);
            4'd4: return 32'(m_incn);
            4'd6: return m_cs;
            4'd7: return 32'(m_cn);
            4'd8: return 32'(m_en);
            default: return 32'd0;
        endcase
    endfunction

    function automatic string read_tag(logic [3:0] ra);
        case (ra)
            4'd0, 4'd2: return "R11";
            4'd1: return "R4";
            4'd3, 4'd4: return "R3";
            4'd6, 4'd7: return "R10";
            4'd8: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic model_reset();
        m_sec = '0; m_ns = 0; m_frac = '0; m_incf = '0; m_stf = '0; m_hi = '0;
        m_snap_hi = '0; m_incn = 8'd8; m_cs = '0; m_cn = '0; m_snap_ns = '0;
        m_en = '0; e_pps = 0; e_cmp = 0;
    endtask

    // reference behaviour at one rising edge, from the pre-edge state
    task automatic model_edge(bit we, logic [3:0] a, logic [31:0] d, bit re, logic [3:0] ra);
        longint sum;
        logic [16:0] fs;
        int stp;
        bit nb, carry, okv;
        carry = 0;
        okv = (longint'(d[29:0]) < BIL);
        if (re && ra == 4'd1) begin
            m_snap_hi = m_sec[47:32];
            m_snap_ns = 30'(m_ns);
        end
        nb = (we && (a == 4'd6 || a == 4'd7)) ? 1'b0 : below(m_sec, m_ns, m_cs, m_cn);
        fs = {1'b0, m_frac} + {1'b0, m_incf};
        stp = int'(m_incn) + int'(fs[16]);
        if (we && a == 4'd1) begin
            m_sec = {m_hi, d};
        end else if (we && a == 4'd2 && okv) begin
            m_ns = longint'(d[29:0]);
            m_frac = '0;
        end else begin
            if (we && a == 4'd5 && okv)
                sum = d[31] ? m_ns - longint'(d[29:0]) : m_ns + longint'(d[29:0]);
            else begin
                sum = m_ns + stp;
                m_frac = fs[15:0];
            end
            if (sum >= BIL) begin sum -= BIL; m_sec = m_sec + 48'd1; carry = 1; end
            else if (sum < 0) begin sum += BIL; m_sec = m_sec - 48'd1; end
            m_ns = sum;
        end
        if (we) begin
            case (a)
                4'd0: m_hi = d[15:0];
                4'd3: m_stf = d[15:0];
                4'd4: begin m_incn = d[7:0]; m_incf = m_stf; end
                4'd6: m_cs = d;
                4'd7: m_cn = d[29:0];
                4'd8: m_en = d[1:0];
                default: ;
            endcase
        end
        e_pps = carry && m_en[0];
        e_cmp = nb && !below(m_sec, m_ns, m_cs, m_cn) && m_en[1];
    endtask

    // one clock: drive at negedge, check read, model the edge, check outputs
    task automatic cyc(bit we, logic [3:0] a, logic [31:0] d, bit re, logic [3:0] ra, string tag);
        wr_en = we; wr_addr = a; wr_data = d; rd_en = re; rd_addr = ra;
        #1;
        chk(rd_data == exp_read(ra), read_tag(ra), "rd_data", longint'(rd_data), longint'(exp_read(ra)));
        @(posedge clk);
        model_edge(we, a, d, re, ra);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk(tod_sec_o == m_sec, tag, "seconds", longint'(tod_sec_o), longint'(m_sec));
        chk(longint'(tod_ns_o) == m_ns, tag, "nanoseconds", longint'(tod_ns_o), m_ns);
        chk(pps_irq_o == e_pps, "R9", "pps_irq", longint'(pps_irq_o), longint'(e_pps));
        chk(cmp_irq_o == e_cmp, "R10", "cmp_irq", longint'(cmp_irq_o), longint'(e_cmp));
        if (cmp_irq_o) cmp_cnt++;
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 32'd0, 1'b0, 4'd4, tag);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, string tag);
        cyc(1'b1, a, d, 1'b0, a, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog timeout");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        longint hold_ns;
        void'($urandom(32'd20170414));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(tod_sec_o == 48'd0, "R1", "seconds", longint'(tod_sec_o), 0);
        chk(tod_ns_o == 30'd0, "R1", "nanoseconds", longint'(tod_ns_o), 0);
        chk(!pps_irq_o && !cmp_irq_o, "R1", "irqs", longint'({pps_irq_o, cmp_irq_o}), 0);
        rd_addr = 4'd4; #1;
        chk(rd_data == 32'd8, "R1", "whole inc", longint'(rd_data), 8);
        rd_addr = 4'd8; #1;
        chk(rd_data == 32'd0, "R1", "irq enable", longint'(rd_data), 0);
        rst_n = 1'b1;

        // R2: plain integer stepping
        idle(10, "R2");
        // R3: staged fraction, commit on whole write
        wr(4'd3, 32'h0000_4000, "R3");
        idle(4, "R3");
        wr(4'd4, 32'd2, "R3");
        idle(12, "R2");
        // R4/R6/R9: set-time sequence near a high-word boundary
        wr(4'd8, 32'd3, "R9");
        wr(4'd2, 32'd0, "R5");
        wr(4'd0, 32'h0000_1234, "R4");
        idle(2, "R4");
        wr(4'd1, 32'hFFFF_FFFF, "R4");
        wr(4'd2, 32'd999_999_980, "R5");
        idle(15, "R6");
        chk(tod_sec_o == 48'h1235_0000_0000, "R6", "high carry", longint'(tod_sec_o), 64'h1235_0000_0000);
        // R5: out-of-range nanosecond writes are ignored
        wr(4'd2, 32'd1_000_000_000, "R5");
        wr(4'd2, 32'h3FFF_FFFF, "R5");
        idle(2, "R5");
        // R7: adjust add, borrow, carry, reject
        wr(4'd2, 32'd100, "R7");
        wr(4'd5, 32'd500, "R7");
        wr(4'd5, 32'h8000_0000 | 32'd1000, "R7");
        idle(1, "R7");
        wr(4'd5, 32'd999_999_999, "R7");
        wr(4'd5, 32'h8000_0000 | 32'd1_000_000_000, "R7");
        idle(3, "R7");
        // R10: compare hit once, then masked
        wr(4'd4, 32'd200, "R10");
        wr(4'd2, 32'd1000, "R10");
        wr(4'd6, m_sec[31:0], "R10");
        cmp_cnt = 0;
        wr(4'd7, 32'd5000, "R10");
        idle(40, "R10");
        chk(cmp_cnt == 1, "R10", "compare pulses", cmp_cnt, 1);
        wr(4'd8, 32'd1, "R10");
        cmp_cnt = 0;
        wr(4'd7, 32'd20000, "R10");
        idle(120, "R10");
        chk(cmp_cnt == 0, "R10", "masked pulses", cmp_cnt, 0);
        // R11: coherent snapshot
        cyc(1'b0, 4'd0, 32'd0, 1'b1, 4'd1, "R11");
        idle(5, "R11");
        cyc(1'b0, 4'd0, 32'd0, 1'b0, 4'd2, "R11");
        cyc(1'b0, 4'd0, 32'd0, 1'b0, 4'd0, "R11");
        // R8: zero increment halts the time
        wr(4'd3, 32'd0, "R8");
        wr(4'd4, 32'd0, "R8");
        hold_ns = longint'(tod_ns_o);
        idle(20, "R8");
        chk(longint'(tod_ns_o) == hold_ns, "R8", "halted ns", longint'(tod_ns_o), hold_ns);
        wr(4'd4, 32'd8, "R3");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [31:0] d;
            logic [3:0] ra;
            r = int'($urandom % 24);
            ra = 4'($urandom % 10);
            case (r)
                0: wr(4'd0, $urandom, "R4");
                1: wr(4'd1, $urandom, "R4");
                2: wr(4'd2, $urandom % 32'd1_100_000_000, "R5");
                3: wr(4'd3, $urandom, "R3");
                4: wr(4'd4, $urandom % 32'd48, "R3");
                5, 6: begin
                    d = {$urandom % 2 == 1, 1'b0, 30'($urandom % 32'd1_050_000_000)};
                    wr(4'd5, d, "R7");
                end
                7: wr(4'd6, m_sec[31:0] + ($urandom % 2), "R10");
                8: wr(4'd7, $urandom % 32'd1_000_000_000, "R10");
                9: wr(4'd8, $urandom, "R9");
                10: cyc(1'b0, 4'd0, 32'd0, 1'b1, 4'd1, "R11");
                default: cyc(1'b0, 4'd0, 32'd0, 1'b0, ra, "R2");
            endcase
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule